// File: doc/BRIEF.md
# Programmable Parallel Ports with Strobed Handshake

This block gives a processor two 8-bit parallel ports (A and B) and one 6-bit port C. Each wide port is set to input or output as a whole by a command byte. Port C is either plain I/O or a set of handshake lines for the wide ports. In a handshake mode, a strobe pin from the peer device latches input data or acknowledges output data. A buffer-full flag and an interrupt flag track each transfer. These flags are driven out on port C and can be read back in a status byte.

The processor reaches the block through a single-cycle register interface with four offsets. A write to offset 0 loads the command byte. A read of offset 0 returns status. Each pin has its own input, output and output-enable signal. Bit 6 of the status byte is a flag supplied by a neighbouring timer block. The command's top two bits are handed on to that timer block. Strobe pins pass through a synchronizer of `SYNC_STAGES` flops before the handshake logic sees them.

Top module: `pio_hs_top`

## Requirements
- R1: After reset the command byte is 0: every pin's output enable is low, and a status read returns 0x00 while the timer flag input is low.
- R2: Offset decode uses bus_addr[2:0]: 0 = command write / status read, 1 = port A, 2 = port B, 3 = port C ({2'b00, six pins}). Reads of offsets 4 to 7 return 0x00. A write with bus_sel low has no effect.
- R3: Command bit 0 makes port A an output (all eight enables high, pins driven from the last value written to offset 1) and bit 1 does the same for port B. A 0 selects input. Reading an output port returns the value written.
- R4: Command bits 3:2 choose the port C mode. 00 is plain input: all six enables low, and a read of offset 3 returns the pin levels. 11 is plain output: all six pins are driven from the value written to offset 3.
- R5: Mode 01 gives port A handshake on port C: C0 outputs A's interrupt flag, C1 outputs A's buffer-full flag, C2 is A's active-low strobe input, and C5..C3 are outputs from the port C value.
- R6: Mode 10 gives handshake for both ports. C2..C0 are as in R5. C3 outputs B's interrupt flag, C4 outputs B's buffer-full flag, and C5 is B's active-low strobe input.
- R7: The status byte reads {0, timer flag, B interrupt enable, B buffer full, B interrupt, A interrupt enable, A buffer full, A interrupt} from bit 7 down to bit 0. Command bits 4 and 5 are the interrupt enables of A and B.
- R8: A handshake port set to input latches its pins and sets buffer-full while its synchronized strobe is low. The strobe's rising edge sets the interrupt flag. A read of the port returns the latched byte and clears both flags.
- R9: A handshake port set to output sets buffer-full and clears its interrupt flag on each processor write. A low strobe clears buffer-full, and the strobe's rising edge sets the interrupt flag.
- R10: The interrupt flag is set on a strobe rising edge only while that port's interrupt enable bit is 1.
- R11: tmr_stat_rd is high during a status read. Every command write presents bits 7:6 on tmr_cmd with a one-cycle tmr_cmd_wr pulse.
- R12: A port that no handshake mode serves holds its buffer-full and interrupt flags at 0. If it is set to input, a read returns its live pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register space selected |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| tmr_flag | input | 1 | Timer status flag from the timer block |
| tmr_stat_rd | output | 1 | Status is being read (timer clears its flag) |
| tmr_cmd | output | 2 | Timer control bits of the last command |
| tmr_cmd_wr | output | 1 | Command written this cycle |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 6 | Port C pin levels |
| pc_out | output | 6 | Port C drive values |
| pc_oe | output | 6 | Port C output enables |

## Verification
The main function is the port C mode combined with port direction, so the bench steps through four settings. Plain input and plain output show that the mode field maps pins to the register, and not to the handshake flags. Port-A-only handshake with input direction separates the latched byte from the live pins. It does this by changing the pins after the strobe, before the read. Both-port handshake with B as output runs the write, acknowledge, interrupt and rewrite sequence. A repeat of the input strobe with its enable off shows that buffer-full still sets while the interrupt flag does not. This separates R8 from R10.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;

    localparam int DATA_W   = 8;
    localparam int PC_W     = 6;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_A    = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_B    = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_C    = 3'd3;

    // port C pin roles in handshake modes
    localparam int PC_A_INT = 0;
    localparam int PC_A_FUL = 1;
    localparam int PC_A_STB = 2;
    localparam int PC_B_INT = 3;
    localparam int PC_B_FUL = 4;
    localparam int PC_B_STB = 5;

    typedef enum logic [1:0] {
        PCM_IN    = 2'b00,
        PCM_HS_A  = 2'b01,
        PCM_HS_AB = 2'b10,
        PCM_OUT   = 2'b11
    } pc_mode_e;

    typedef struct packed {
        logic [1:0] tmr;
        logic       ien_b;
        logic       ien_a;
        pc_mode_e   pcm;
        logic       out_b;
        logic       out_a;
    } cmd_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic tmr, input logic ien_b, input logic ful_b, input logic int_b,
        input logic ien_a, input logic ful_a, input logic int_a);
        return {1'b0, tmr, ien_b, ful_b, int_b, ien_a, ful_a, int_a};
    endfunction

endpackage

// File: rtl/pio_hs_port.sv
module pio_hs_port
    import pio_hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_en,
    input  logic              dir_out,
    input  logic              ien,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] in_q,
    output logic              ful,
    output logic              irq
);
    localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [SS-1:0] sy;
    logic          stb_d;
    logic          stb_s;
    logic          stb_low;
    logic          stb_rise;

    assign stb_s    = sy[SS-1];
    assign stb_low  = !stb_s;
    assign stb_rise = stb_s && !stb_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy    <= '1;
            stb_d <= 1'b1;
            out_q <= '0;
            in_q  <= '0;
            ful   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            sy    <= {sy[SS-2:0], stb_n};
            stb_d <= stb_s;
            if (cpu_wr) out_q <= wdata;
            if (!hs_en) begin
                ful <= 1'b0;
                irq <= 1'b0;
            end else if (!dir_out) begin
                if (cpu_rd) begin
                    ful <= 1'b0;
                    irq <= 1'b0;
                end
                if (stb_low) begin
                    in_q <= pin_in;
                    ful  <= 1'b1;
                end
                if (stb_rise && ien) irq <= 1'b1;
            end else begin
                if (cpu_wr) begin
                    ful <= 1'b1;
                    irq <= 1'b0;
                end
                if (stb_low) ful <= 1'b0;
                if (stb_rise && ien) irq <= 1'b1;
            end
        end
    end

    // R8
    in_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_en && !dir_out && stb_low) |=> ful);
    // R8
    in_read_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_en && !dir_out && cpu_rd && !stb_low && !stb_rise) |=> (!ful && !irq));
    // R9
    out_write_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_en && dir_out && cpu_wr && !stb_low) |=> ful);
    // R10
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_en && stb_rise && ien) |=> irq);
    // R12
    idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !hs_en |=> (!ful && !irq));

endmodule

// File: rtl/pio_hs_cmux.sv
module pio_hs_cmux
    import pio_hs_pkg::*;
(
    input  pc_mode_e          mode,
    input  logic [PC_W-1:0]   pc_reg,
    input  logic              a_irq,
    input  logic              a_ful,
    input  logic              b_irq,
    input  logic              b_ful,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_oe
);
    always_comb begin
        pc_out = pc_reg;
        pc_oe  = '0;
        case (mode)
            PCM_IN: pc_oe = '0;
            PCM_OUT: pc_oe = '1;
            PCM_HS_A: begin
                pc_oe           = '1;
                pc_oe[PC_A_STB] = 1'b0;
                pc_out[PC_A_INT] = a_irq;
                pc_out[PC_A_FUL] = a_ful;
                pc_out[PC_A_STB] = 1'b0;
            end
            PCM_HS_AB: begin
                pc_oe           = '1;
                pc_oe[PC_A_STB] = 1'b0;
                pc_oe[PC_B_STB] = 1'b0;
                pc_out[PC_A_INT] = a_irq;
                pc_out[PC_A_FUL] = a_ful;
                pc_out[PC_A_STB] = 1'b0;
                pc_out[PC_B_INT] = b_irq;
                pc_out[PC_B_FUL] = b_ful;
                pc_out[PC_B_STB] = 1'b0;
            end
            default: pc_oe = '0;
        endcase
    end
endmodule

// File: rtl/pio_hs_top.sv
module pio_hs_top
    import pio_hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tmr_flag,
    output logic              tmr_stat_rd,
    output logic [1:0]        tmr_cmd,
    output logic              tmr_cmd_wr,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [PC_W-1:0]   pc_in,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   pc_oe
);
    localparam int NPORT = 2;

    cmd_t                        cmd_q;
    logic [PC_W-1:0]             pc_reg;
    logic [NPORT-1:0]            hs_en, dir_out, ien, stb_n, p_wr, p_rd, ful, irq;
    logic [NPORT-1:0][DATA_W-1:0] p_in, p_out, p_lat, p_val;
    logic [PC_W-1:0]             pc_val;
    logic                        wr_any, rd_any;

    assign wr_any = bus_sel && bus_wr;
    assign rd_any = bus_sel && bus_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            pc_reg <= '0;
        end else if (wr_any) begin
            if (bus_addr == OFS_CTRL) cmd_q <= cmd_t'(bus_wdata);
            if (bus_addr == OFS_C)    pc_reg <= bus_wdata[PC_W-1:0];
        end
    end

    assign hs_en[0]   = (cmd_q.pcm == PCM_HS_A) || (cmd_q.pcm == PCM_HS_AB);
    assign hs_en[1]   = (cmd_q.pcm == PCM_HS_AB);
    assign dir_out    = {cmd_q.out_b, cmd_q.out_a};
    assign ien        = {cmd_q.ien_b, cmd_q.ien_a};
    assign stb_n      = {pc_in[PC_B_STB], pc_in[PC_A_STB]};
    assign p_in       = {pb_in, pa_in};
    assign p_wr       = {wr_any && (bus_addr == OFS_B), wr_any && (bus_addr == OFS_A)};
    assign p_rd       = {rd_any && (bus_addr == OFS_B), rd_any && (bus_addr == OFS_A)};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pio_hs_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
            .clk     (clk),
            .rst     (rst),
            .hs_en   (hs_en[p]),
            .dir_out (dir_out[p]),
            .ien     (ien[p]),
            .stb_n   (stb_n[p]),
            .pin_in  (p_in[p]),
            .cpu_wr  (p_wr[p]),
            .cpu_rd  (p_rd[p]),
            .wdata   (bus_wdata),
            .out_q   (p_out[p]),
            .in_q    (p_lat[p]),
            .ful     (ful[p]),
            .irq     (irq[p])
        );
        assign p_val[p] = dir_out[p] ? p_out[p] : (hs_en[p] ? p_lat[p] : p_in[p]);
    end

    assign pa_out = p_out[0];
    assign pb_out = p_out[1];
    assign pa_oe  = {DATA_W{dir_out[0]}};
    assign pb_oe  = {DATA_W{dir_out[1]}};

    pio_hs_cmux u_cmux (
        .mode   (cmd_q.pcm),
        .pc_reg (pc_reg),
        .a_irq  (irq[0]),
        .a_ful  (ful[0]),
        .b_irq  (irq[1]),
        .b_ful  (ful[1]),
        .pc_out (pc_out),
        .pc_oe  (pc_oe)
    );

    assign pc_val = (pc_oe & pc_out) | (~pc_oe & pc_in);

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = pack_status(tmr_flag, cmd_q.ien_b, ful[1], irq[1],
                                              cmd_q.ien_a, ful[0], irq[0]);
            OFS_A:    bus_rdata = p_val[0];
            OFS_B:    bus_rdata = p_val[1];
            OFS_C:    bus_rdata = {{(DATA_W-PC_W){1'b0}}, pc_val};
            default:  bus_rdata = '0;
        endcase
    end

    assign tmr_stat_rd = rd_any && (bus_addr == OFS_CTRL);
    assign tmr_cmd     = cmd_q.tmr;
    assign tmr_cmd_wr  = wr_any && (bus_addr == OFS_CTRL);

    // R4
    plain_in_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.pcm == PCM_IN) |-> (pc_oe == '0));
    // R5
    hs_a_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.pcm == PCM_HS_A) |-> (!pc_oe[PC_A_STB] && pc_out[PC_A_FUL] == ful[0]
                                     && pc_out[PC_A_INT] == irq[0]));
    // R6
    hs_b_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.pcm == PCM_HS_AB) |-> (!pc_oe[PC_B_STB] && pc_out[PC_B_FUL] == ful[1]
                                      && pc_out[PC_B_INT] == irq[1]));
    // R11
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_cmd_wr |=> (tmr_cmd == $past(bus_wdata[7:6])));

endmodule

// File: tb/pio_hs_top_tb.sv
module pio_hs_top_tb_top;
    import pio_hs_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0, tmr_flag = 0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic tmr_stat_rd, tmr_cmd_wr;
    logic [1:0] tmr_cmd;
    logic [7:0] pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
    logic [5:0] pc_in = '0, pc_out, pc_oe;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_hs_top #(.SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_flag(tmr_flag), .tmr_stat_rd(tmr_stat_rd), .tmr_cmd(tmr_cmd),
        .tmr_cmd_wr(tmr_cmd_wr),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data while a read strobe is up
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd && exp_q.size() > 0) begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(bus_rdata, e, t);
                chk({7'b0, tmr_stat_rd}, {7'b0, bus_addr == 3'd0}, "R11 stat_rd");
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_sel = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 0; bus_sel = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(pa_oe, 8'h00, "R1 pa_oe");
        chk(pb_oe, 8'h00, "R1 pb_oe");
        chk({2'b0, pc_oe}, 8'h00, "R1 pc_oe");
        bus_read(3'd0, 8'h00, "R1 status");

        tmr_flag = 1;
        bus_read(3'd0, 8'h40, "R7 timer bit");
        tmr_flag = 0;

        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 6'h2B;
        bus_read(3'd1, 8'h5A, "R12 live A");
        bus_read(3'd2, 8'hC3, "R2 live B");
        bus_read(3'd3, 8'h2B, "R4 plain in C");
        bus_read(3'd5, 8'h00, "R2 high offset");
        pc_in = 6'h24;

        // stray write without select
        @(negedge clk); bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h03;
        @(negedge clk); bus_wr = 0;
        chk(pa_oe, 8'h00, "R2 unselected write");

        bus_write(3'd0, 8'h03);
        bus_write(3'd1, 8'h11);
        bus_write(3'd2, 8'h22);
        #1;
        chk(pa_oe, 8'hFF, "R3 pa_oe"); chk(pa_out, 8'h11, "R3 pa_out");
        chk(pb_oe, 8'hFF, "R3 pb_oe"); chk(pb_out, 8'h22, "R3 pb_out");
        bus_read(3'd1, 8'h11, "R3 read A");

        bus_write(3'd0, 8'h0C);
        bus_write(3'd3, 8'h15);
        #1;
        chk({2'b0, pc_oe}, 8'h3F, "R4 plain out oe");
        chk({2'b0, pc_out}, 8'h15, "R4 plain out val");
        bus_read(3'd3, 8'h15, "R4 read C");

        // port A handshake input, interrupt enabled
        bus_write(3'd0, 8'h14);
        #1;
        chk({2'b0, pc_oe}, 8'h3B, "R5 oe");
        chk({2'b0, pc_out}, 8'h10, "R5 out");
        bus_read(3'd0, 8'h04, "R7 inte A");
        pa_in = 8'hA7;
        @(negedge clk); pc_in[2] = 1'b0;
        wait_cyc(4);
        bus_read(3'd0, 8'h06, "R8 bf set");
        chk({2'b0, pc_out}, 8'h12, "R5 bf pin");
        pc_in[2] = 1'b1;
        wait_cyc(4);
        bus_read(3'd0, 8'h07, "R8 intr set");
        chk({2'b0, pc_out}, 8'h13, "R5 intr pin");
        pa_in = 8'h00;
        bus_read(3'd1, 8'hA7, "R8 latched");
        bus_read(3'd0, 8'h04, "R8 cleared");

        // interrupt disabled
        bus_write(3'd0, 8'h04);
        @(negedge clk); pc_in[2] = 1'b0;
        wait_cyc(4); pc_in[2] = 1'b1;
        wait_cyc(4);
        bus_read(3'd0, 8'h02, "R10 no intr");
        bus_read(3'd1, 8'h00, "R8 relatch");

        // both ports handshake, B output, inte B
        bus_write(3'd0, 8'h2A);
        #1;
        chk({2'b0, pc_oe}, 8'h1B, "R6 oe");
        bus_write(3'd2, 8'h3C);
        #1;
        chk(pb_out, 8'h3C, "R9 pb_out");
        chk({2'b0, pc_out}, 8'h10, "R6 bf pin");
        bus_read(3'd0, 8'h30, "R9 bf on write");
        @(negedge clk); pc_in[5] = 1'b0;
        wait_cyc(4);
        bus_read(3'd0, 8'h20, "R9 ack clears bf");
        pc_in[5] = 1'b1;
        wait_cyc(4);
        bus_read(3'd0, 8'h28, "R9 intr");
        chk({2'b0, pc_out}, 8'h08, "R6 intr pin");
        bus_write(3'd2, 8'h44);
        bus_read(3'd0, 8'h30, "R9 rewrite");

        bus_write(3'd0, 8'hC0);
        #1;
        chk({6'b0, tmr_cmd}, 8'h03, "R11 tmr_cmd");
        chk({2'b0, pc_oe}, 8'h00, "R4 back to plain in");
        bus_read(3'd0, 8'h00, "R12 flags dropped");

        wait_cyc(2);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2: actual %0d expected 0 pending reads", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule